// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block owns the program counter of a small fetch-decode-execute core during the entry into and the return from interrupt handling. It keeps one pending flag for each interrupt source, one enable bit for each source and a single global enable. Every time the core reaches an instruction boundary, the block picks the next PC. If no interrupt can be taken, it loads the next sequential address from the core. If an interrupt can be taken, it runs an interrupt cycle instead: the next address goes onto a small hardware return stack, the PC goes to one shared vector, and the global enable is cleared.

A return strobe pops the saved address back into the PC and turns the global enable on again. Flags stay set after entry, so a handler can poll them to find the source. It then clears them with a register write. The same write port loads the per-source enables and the global enable. The return stack reports overflow and underflow through sticky error bits.

Top module: `irq_seq_top`

## Requirements
- R1: After a synchronous reset, pc_o is 0000h, flags_o, en_o and gie_o are all 0, taken_o is 0 and both error bits are 0.
- R2: An event bit high in a cycle sets the matching flag from the next cycle on, whatever its enable. A flag stays set, including across an interrupt entry, until a write with wr_sel_i=0 carries a 1 in its bit position.
- R3: When an event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R4: At a boundary strobe, an interrupt cycle is taken only if (flags_o & en_o) is nonzero and gie_o is 1. Otherwise pc_o takes next_pc_i on the following cycle.
- R5: An interrupt cycle sets pc_o to 0004h, pushes next_pc_i, clears gie_o and raises taken_o for exactly one cycle.
- R6: A return strobe loads pc_o from the top of the return stack and sets gie_o in the same cycle. A boundary strobe in that same cycle is ignored.
- R7: The return stack holds 8 addresses and returns them in last-in, first-out order across nested entries.
- R8: An entry while the stack holds 8 addresses sets a sticky overflow bit and drops the push. The PC still goes to the vector.
- R9: A return with an empty stack sets a sticky underflow bit and leaves pc_o unchanged.
- R10: A write with wr_sel_i=1 loads en_o from wr_data_i. A write with wr_sel_i=2 loads gie_o from wr_data_i bit 0, unless an entry or a return happens in that cycle; those take priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NSRC | Per-source event pulses |
| boundary_i | input | 1 | Instruction boundary strobe |
| next_pc_i | input | PC_W | Address of the next sequential instruction |
| reti_i | input | 1 | Return-from-interrupt strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 flag clear, 1 enables, 2 global enable |
| wr_data_i | input | NSRC | Write data |
| pc_o | output | PC_W | Program counter |
| flags_o | output | NSRC | Pending flags |
| en_o | output | NSRC | Per-source enables |
| gie_o | output | 1 | Global enable |
| taken_o | output | 1 | One-cycle pulse after an interrupt cycle |
| ovf_o | output | 1 | Sticky return stack overflow |
| unf_o | output | 1 | Sticky return stack underflow |

## Verification
The assertions check several rules on every cycle. An event always leaves its flag set, and a clear without an event leaves it cleared. A qualified boundary always leads to an entry. An entry always leaves the PC at the vector with the global enable off. A return always turns the global enable back on. The stack fill level never goes past its depth, and the overflow bit stays set once raised. Other behaviours need the bench's scenarios to show them. These are the last-in, first-out order of the saved addresses, the exact address loaded on return, the precedence rules between same-cycle strobes, and the full sweep over flag, enable and global-enable combinations.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SEL_FLAG_CLR = 2'd0,
    SEL_ENABLE   = 2'd1,
    SEL_GLOBAL   = 2'd2,
    SEL_NONE     = 2'd3
  } wsel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_wr_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] en_o,
  output logic            pending_o
);
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        // a new event beats a same-cycle clear
        flag_q[i] <= evt_i[i] | (flag_q[i] & ~(clr_wr_i & data_i[i]));
        if (en_wr_i) en_q[i] <= data_i[i];
      end
    end

    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
      evt_i[i] |=> flag_q[i]);
    // R2
    clr_done_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_wr_i && data_i[i] && !evt_i[i]) |=> !flag_q[i]);
  end

  assign flags_o   = flag_q;
  assign en_o      = en_q;
  assign pending_o = |(flag_q & en_q);
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] top_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          empty;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] top_idx;
  logic          ovf_q;
  logic          unf_q;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_idx  = AW'(cnt_q);
  assign top_idx = AW'(cnt_q - 1'b1);

  always_ff @(posedge clk) begin
    if (push_i && !full) mem[wr_idx] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (push_i) begin
        if (full) ovf_q <= 1'b1;
        else      cnt_q <= cnt_q + 1'b1;
      end else if (pop_i) begin
        if (empty) unf_q <= 1'b1;
        else       cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign top_o   = mem[top_idx];
  assign empty_o = empty;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_q |=> unf_q);
  // R6
  no_dual_op_chk: assert property (@(posedge clk) disable iff (rst)
    !(push_i && pop_i));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
  parameter int              NSRC   = 4,
  parameter int              PC_W   = 16,
  parameter int              DEPTH  = 8,
  parameter logic [PC_W-1:0] VECTOR = 16'h0004
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic            boundary_i,
  input  logic [PC_W-1:0] next_pc_i,
  input  logic            reti_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [PC_W-1:0] pc_o,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] en_o,
  output logic            gie_o,
  output logic            taken_o,
  output logic            ovf_o,
  output logic            unf_o
);
  import irq_seq_pkg::*;

  wsel_e           sel;
  logic            clr_wr;
  logic            en_wr;
  logic            gie_wr;
  logic            pending;
  logic            take;
  logic [PC_W-1:0] stack_top;
  logic            stack_empty;
  logic [PC_W-1:0] pc_q;
  logic            gie_q;
  logic            taken_q;

  assign sel    = wsel_e'(wr_sel_i);
  assign clr_wr = wr_en_i && (sel == SEL_FLAG_CLR);
  assign en_wr  = wr_en_i && (sel == SEL_ENABLE);
  assign gie_wr = wr_en_i && (sel == SEL_GLOBAL);

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .clr_wr_i  (clr_wr),
    .en_wr_i   (en_wr),
    .data_i    (wr_data_i),
    .flags_o   (flags_o),
    .en_o      (en_o),
    .pending_o (pending)
  );

  // return strobe has precedence over the boundary
  assign take = boundary_i && !reti_i && gie_q && pending;

  irq_ret_stack #(.DEPTH(DEPTH), .DW(PC_W)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (take),
    .pop_i   (reti_i),
    .din_i   (next_pc_i),
    .top_o   (stack_top),
    .empty_o (stack_empty),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      gie_q   <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= take;
      if (reti_i) begin
        if (!stack_empty) pc_q <= stack_top;
        gie_q <= 1'b1;
      end else if (take) begin
        pc_q  <= VECTOR;
        gie_q <= 1'b0;
      end else begin
        if (boundary_i) pc_q <= next_pc_i;
        if (gie_wr)     gie_q <= wr_data_i[0];
      end
    end
  end

  assign pc_o    = pc_q;
  assign gie_o   = gie_q;
  assign taken_o = taken_q;

  // R4
  entry_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !reti_i && gie_o && |(flags_o & en_o)) |=> taken_o);
  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!boundary_i || reti_i || !gie_o) |=> !taken_o);
  // R5
  entry_state_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (pc_o == VECTOR) && !gie_o);
  // R6
  reti_gie_chk: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> gie_o);
endmodule

// File: tb/test_irq_seq_top.sv
module test_irq_seq_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  evt;
  logic        boundary;
  logic [15:0] npc;
  logic        reti;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [3:0]  wr_data;
  logic [15:0] pc;
  logic [3:0]  flags, en;
  logic        gie, taken, ovf, unf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_seq_top i_irq_seq_top (
    .clk(clk), .rst(rst), .evt_i(evt), .boundary_i(boundary), .next_pc_i(npc),
    .reti_i(reti), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .pc_o(pc), .flags_o(flags), .en_o(en), .gie_o(gie), .taken_o(taken),
    .ovf_o(ovf), .unf_o(unf)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [3:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    evt = '0; boundary = 0; npc = '0; reti = 0; wr_en = 0; wr_sel = '0; wr_data = '0;
    do_reset();
    // R1 reset state
    check("R1 pc", pc, 16'h0000);
    check("R1 flags", flags, 0);
    check("R1 en", en, 0);
    check("R1 gie", gie, 0);
    check("R1 taken", taken, 0);
    check("R1 err", {ovf, unf}, 0);

    // Sweep of flags x enables x global enable
    for (int g = 0; g < 2; g++)
      for (int ev = 0; ev < 16; ev++)
        for (int ie = 0; ie < 16; ie++) begin
          logic        exp_t;
          logic [15:0] addr;
          wr(2'd0, 4'hF);
          wr(2'd1, 4'(ie));
          wr(2'd2, 4'(g));
          check("R10 en", en, ie);
          check("R10 gie", gie, g);
          evt = 4'(ev);
          step();
          evt = '0;
          check("R2 flags set", flags, ev);
          addr = 16'h1000 + 16'(g * 256 + ev * 16 + ie);
          boundary = 1'b1; npc = addr;
          step();
          boundary = 1'b0;
          exp_t = (g == 1) && ((ev & ie) != 0);
          check("R4 taken", taken, exp_t);
          check("R4 pc", pc, exp_t ? 16'h0004 : addr);
          check("R5 gie", gie, exp_t ? 1'b0 : 1'(g));
          check("R2 flags persist", flags, ev);
          if (exp_t) begin
            reti = 1'b1;
            step();
            reti = 1'b0;
            check("R5 taken one cycle", taken, 0);
            check("R6 pc", pc, addr);
            check("R6 gie", gie, 1);
          end
        end
    check("R8 no ovf", ovf, 0);
    check("R9 no unf", unf, 0);

    // R3 set beats clear
    wr(2'd0, 4'hF);
    evt = 4'hF; step(); evt = '0;
    evt = 4'h1; wr_en = 1; wr_sel = 2'd0; wr_data = 4'hF; step();
    evt = '0; wr_en = 0;
    check("R3 set wins", flags, 4'h1);
    wr(2'd0, 4'h1);
    check("R2 cleared", flags, 4'h0);

    // R7/R8 nested entries
    do_reset();
    wr(2'd1, 4'hF);
    evt = 4'h2; step(); evt = '0;
    for (int k = 0; k < 9; k++) begin
      wr(2'd2, 4'h1);
      boundary = 1'b1; npc = 16'h0100 + 16'(k);
      step();
      boundary = 1'b0;
      check("R7 entry pc", pc, 16'h0004);
      check("R8 ovf", ovf, (k == 8) ? 1'b1 : 1'b0);
    end
    for (int k = 7; k >= 0; k--) begin
      reti = 1'b1; step(); reti = 1'b0;
      check("R7 lifo pc", pc, 16'h0100 + 16'(k));
    end
    check("R9 no unf yet", unf, 0);
    reti = 1'b1; step(); reti = 1'b0;
    check("R9 unf", unf, 1);
    check("R9 pc kept", pc, 16'h0100);
    check("R8 ovf sticky", ovf, 1);

    // R6 return beats a same-cycle boundary; R10 entry beats gie write
    do_reset();
    wr(2'd1, 4'h4);
    evt = 4'h4; step(); evt = '0;
    wr(2'd2, 4'h1);
    boundary = 1'b1; npc = 16'h0321;
    wr_en = 1; wr_sel = 2'd2; wr_data = 4'h1;
    step();
    boundary = 1'b0; wr_en = 0;
    check("R10 entry over write", gie, 0);
    check("R5 pc", pc, 16'h0004);
    reti = 1'b1; boundary = 1'b1; npc = 16'h0555;
    wr_en = 1; wr_sel = 2'd2; wr_data = 4'h0;
    step();
    reti = 1'b0; boundary = 1'b0; wr_en = 0;
    check("R6 reti over boundary", pc, 16'h0321);
    check("R6 gie over write", gie, 1);
    step();
    check("R6 no entry", taken, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule